// File: doc/BRIEF.md
# Dual-Direction Rotor Cipher Core

This block is a lightweight 16-bit rotor cipher engine that runs the same hardware in both directions. Four 16-bit rotor registers and a 16-bit linear feedback generator make up its running state. Each data word passes through four keyed substitution-permutation stages, one per clock. In the forward direction each stage adds a rotor before enciphering. In the reverse direction the stages run last-to-first: each stage deciphers and then subtracts its rotor. One shared modulo-2^16 add/subtract unit serves both directions.

The first start after reset seeds the state before it handles the block. The rotors are loaded from a 64-bit nonce bus, one rotor per clock. Then four keyed iterations mix them, and the last result seeds the generator. After every block, in either direction, all four rotors and the generator step with the same rule. Because of this, two cores built from the same nonces and subkeys stay in lock-step. This holds even when a stream switches between enciphering and deciphering. A two-bit mode selects fixed forward, fixed reverse, or one of two alternating orders.

Top module: `rotor_cipher_core`

## Requirements
- R1: While and after reset, with no start, busy, ready and outValid are low and dataOut is zero.
- R2: The first start after reset loads rotor k from nonces bits [16k+15:16k], one rotor per clock, for 4 clocks. It then runs 4 seeding iterations of 4 clocks each and then the block. outValid rises after the 24th rising edge following the edge that sampled start, and ready is high from then on.
- R3: Once ready, a block spans 4 clocks. outValid is a one-clock pulse after the 4th edge following the start edge, and busy is high while the block runs. dataOut holds its value until the next block completes.
- R4: A start seen while busy is ignored. The running block keeps its timing, its captured data and its direction, and no extra block follows.
- R5: Mode 0 always enciphers and mode 1 always deciphers. Two cores given identical nonces and subkeys recover every plaintext when one runs mode 0 and the other runs mode 1, including the words 0x0000 and 0xFFFF and after the two cores swap roles.
- R6: Mode 2 enciphers its first block and deciphers the next, alternating from then on. Mode 3 does the opposite. Both combined modes have bit 1 set. A core in mode 2 paired with a core in mode 3 recovers every plaintext.
- R7: The same plaintext given in two consecutive forward blocks yields different ciphertexts, because the state steps after every block.
- R8: A start whose mode differs from the mode of the previous block begins the alternation at that mode's first direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to process dataIn; the first one also seeds the state |
| mode | input | 2 | Direction mode: 0 forward, 1 reverse, 2 forward-then-reverse, 3 reverse-then-forward |
| nonces | input | 64 | Four 16-bit rotor seeds, rotor 0 in the low bits |
| subkeys | input | 256 | Four 64-bit stage keys, stage 0 in the low bits |
| dataIn | input | 16 | Word to encipher or decipher, captured on the start edge |
| dataOut | output | 16 | Result of the last completed block |
| busy | output | 1 | Seeding or a block is in progress |
| ready | output | 1 | State has been seeded |
| outValid | output | 1 | One-clock pulse when dataOut is updated |

## Verification
Two cores receive the same seeds and keys. Every block is enciphered by one core and deciphered by the other, so a mismatch in any stage, key order, rotor subtraction or state step shows up as a wrong recovered word. The stream first runs fixed directions with all-zero, all-one and repeated words; the repeated word shows whether the state really advances. It then runs the two alternating modes in both pairings and switches modes mid-stream, which separates a correct restart of the alternation from a stale one. Directed cases cover the seeding latency, the single-cycle valid pulse and a start pulse injected mid-block.

// File: rtl/rotor_pkg.sv
package rotor_pkg;
  localparam int WORD   = 16;
  localparam int STAGES = 4;
  localparam int ROUNDS = 4;
  localparam int KEYW   = ROUNDS * WORD;
  localparam int NIB    = WORD / 4;
  localparam logic [WORD-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [WORD-1:0] SEED_BIT  = 16'h1000;

  typedef logic [WORD-1:0] word_t;

  typedef enum logic [1:0] {
    MODE_ENC     = 2'd0,
    MODE_DEC     = 2'd1,
    MODE_ENC_DEC = 2'd2,
    MODE_DEC_ENC = 2'd3
  } mode_e;

  typedef struct packed {
    logic       loadNonce;
    logic       stageEn;
    logic       decDir;
    logic       initIter;
    logic       rotorStep;
    logic       seedLfsr;
    logic       captureIn;
    logic       outStrobe;
    logic [1:0] step;
  } ctl_t;

  function automatic logic [3:0] sbox(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'h6;  4'h1: y = 4'hB;  4'h2: y = 4'h3;  4'h3: y = 4'hE;
      4'h4: y = 4'h0;  4'h5: y = 4'h9;  4'h6: y = 4'hD;  4'h7: y = 4'h4;
      4'h8: y = 4'hA;  4'h9: y = 4'h1;  4'hA: y = 4'hF;  4'hB: y = 4'h7;
      4'hC: y = 4'hC;  4'hD: y = 4'h2;  4'hE: y = 4'h8;  default: y = 4'h5;
    endcase
    return y;
  endfunction

  function automatic logic [3:0] sboxInv(input logic [3:0] y);
    logic [3:0] r;
    r = 4'h0;
    for (int i = 0; i < 16; i++) begin
      if (sbox(4'(i)) == y) r = 4'(i);
    end
    return r;
  endfunction

  function automatic word_t subLayer(input word_t x, input logic inv);
    word_t y;
    y = '0;
    for (int n = 0; n < NIB; n++) begin
      y[4*n +: 4] = inv ? sboxInv(x[4*n +: 4]) : sbox(x[4*n +: 4]);
    end
    return y;
  endfunction

  // bit i moves to 4*i mod 15; applying it twice is the identity
  function automatic word_t permute(input word_t x);
    word_t y;
    y = '0;
    for (int i = 0; i < WORD - 1; i++) begin
      y[(i * 4) % (WORD - 1)] = x[i];
    end
    y[WORD-1] = x[WORD-1];
    return y;
  endfunction

  function automatic word_t lfsrStep(input word_t s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction
endpackage

// File: rtl/rotor_block_cipher.sv
module rotor_block_cipher
  import rotor_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  word_t            din,
  input  logic [KEYW-1:0]  key,
  output word_t            dout
);
  word_t rk [ROUNDS];
  word_t tailKeyA, tailKeyB;

  always_comb begin
    for (int r = 0; r < ROUNDS; r++) rk[r] = key[r*WORD +: WORD];
  end

  assign tailKeyA = rk[0] ^ rk[2];
  assign tailKeyB = rk[1] ^ rk[3];

  generate
    if (!INVERSE) begin : g_fwd
      word_t acc;
      always_comb begin
        acc = din;
        for (int r = 0; r < ROUNDS; r++) acc = permute(subLayer(acc ^ rk[r], 1'b0));
        acc = subLayer(acc ^ tailKeyA, 1'b0) ^ tailKeyB;
      end
      assign dout = acc;
    end else begin : g_inv
      word_t acc;
      always_comb begin
        acc = subLayer(din ^ tailKeyB, 1'b1) ^ tailKeyA;
        for (int r = ROUNDS - 1; r >= 0; r--) acc = subLayer(permute(acc), 1'b1) ^ rk[r];
      end
      assign dout = acc;
    end
  endgenerate
endmodule

// File: rtl/rotor_control.sv
module rotor_control
  import rotor_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] mode,
  output ctl_t       ctl,
  output logic       busy,
  output logic       ready,
  output logic       outValid
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_INIT, S_RUN} state_e;

  state_e     state;
  logic [1:0] step, iter;
  logic       dirDec, turn;
  mode_e      modeReg;
  logic       turnEff, pickDec;

  always_comb begin
    turnEff = (mode_e'(mode) == modeReg) ? turn : 1'b0;
    case (mode_e'(mode))
      MODE_ENC:     pickDec = 1'b0;
      MODE_DEC:     pickDec = 1'b1;
      MODE_ENC_DEC: pickDec = turnEff;
      default:      pickDec = ~turnEff;
    endcase
  end

  always_comb begin
    ctl = '0;
    ctl.step = step;
    case (state)
      S_IDLE: ctl.captureIn = start;
      S_LOAD: ctl.loadNonce = 1'b1;
      S_INIT: begin
        ctl.stageEn   = 1'b1;
        ctl.initIter  = 1'b1;
        ctl.rotorStep = (step == 2'd3);
        ctl.seedLfsr  = (step == 2'd3) && (iter == 2'd3);
      end
      default: begin
        ctl.stageEn   = 1'b1;
        ctl.decDir    = dirDec;
        ctl.rotorStep = (step == 2'd3);
        ctl.outStrobe = (step == 2'd3);
      end
    endcase
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      step     <= '0;
      iter     <= '0;
      ready    <= 1'b0;
      dirDec   <= 1'b0;
      turn     <= 1'b0;
      modeReg  <= MODE_ENC;
      outValid <= 1'b0;
    end else begin
      outValid <= 1'b0;
      case (state)
        S_IDLE: begin
          step <= '0;
          if (start) begin
            modeReg <= mode_e'(mode);
            dirDec  <= pickDec;
            turn    <= turnEff;
            state   <= ready ? S_RUN : S_LOAD;
          end
        end
        S_LOAD: begin
          step <= step + 2'd1;
          if (step == 2'd3) begin
            state <= S_INIT;
            iter  <= '0;
          end
        end
        S_INIT: begin
          step <= step + 2'd1;
          if (step == 2'd3) begin
            if (iter == 2'd3) begin
              state <= S_RUN;
              ready <= 1'b1;
            end else begin
              iter <= iter + 2'd1;
            end
          end
        end
        default: begin
          step <= step + 2'd1;
          if (step == 2'd3) begin
            state    <= S_IDLE;
            outValid <= 1'b1;
            turn     <= modeReg[1] ? ~turn : 1'b0;
          end
        end
      endcase
    end
  end

  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(dirDec) && $stable(modeReg)));

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R3
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (ready && !ctl.stageEn));

  // R5
  mode_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && modeReg == MODE_ENC) |-> !dirDec);
endmodule

// File: rtl/rotor_datapath.sv
module rotor_datapath
  import rotor_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_t                     ctl,
  input  logic [STAGES*WORD-1:0]   nonces,
  input  logic [STAGES*KEYW-1:0]   subkeys,
  input  word_t                    dataIn,
  output word_t                    dataOut
);
  word_t rs  [STAGES];
  word_t mid [STAGES-1];
  word_t lfsr, work, dataReg, outReg;

  logic [1:0]      sel, midIdx;
  word_t           stageIn, rsSel, invOut, operand, arith, fwdOut, stageOut;
  logic [KEYW-1:0] keySel;
  word_t           lNext, r1Next, r2Next, r3Next, r4Next;

  assign sel    = ctl.decDir ? (2'(STAGES - 1) - ctl.step) : ctl.step;
  assign midIdx = ctl.decDir ? (2'(STAGES - 2) - ctl.step) : ctl.step;

  always_comb begin
    if (ctl.step == 2'd0) stageIn = ctl.initIter ? (rs[0] + rs[2]) : dataReg;
    else                  stageIn = work;
    rsSel  = rs[sel];
    keySel = subkeys[sel*KEYW +: KEYW];
  end

  rotor_block_cipher #(.INVERSE(1'b0)) u_fwd (.din(arith),   .key(keySel), .dout(fwdOut));
  rotor_block_cipher #(.INVERSE(1'b1)) u_inv (.din(stageIn), .key(keySel), .dout(invOut));

  // one adder serves both directions
  assign operand  = ctl.decDir ? invOut : stageIn;
  assign arith    = ctl.decDir ? (operand - rsSel) : (operand + rsSel);
  assign stageOut = ctl.decDir ? arith : fwdOut;

  always_comb begin
    lNext  = lfsrStep(lfsr);
    r1Next = rs[0] + mid[2];
    r3Next = rs[2] + mid[1] + lNext;
    r4Next = rs[3] + mid[0] + r1Next;
    r2Next = rs[1] + mid[0] + r4Next;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) rs[i] <= '0;
      for (int i = 0; i < STAGES - 1; i++) mid[i] <= '0;
      lfsr    <= '0;
      work    <= '0;
      dataReg <= '0;
      outReg  <= '0;
    end else begin
      if (ctl.captureIn) dataReg <= dataIn;
      if (ctl.loadNonce) rs[ctl.step] <= nonces[ctl.step*WORD +: WORD];
      if (ctl.stageEn) begin
        work <= stageOut;
        if (ctl.step != 2'(STAGES - 1)) mid[midIdx] <= stageOut;
      end
      if (ctl.rotorStep) begin
        if (ctl.initIter) begin
          rs[0] <= rs[0] + mid[0];
          rs[1] <= rs[1] + mid[1];
          rs[2] <= rs[2] + mid[2];
          rs[3] <= rs[3] + stageOut;
          if (ctl.seedLfsr) lfsr <= stageOut | SEED_BIT;
        end else begin
          rs[0] <= r1Next;
          rs[1] <= r2Next;
          rs[2] <= r3Next;
          rs[3] <= r4Next;
          lfsr  <= lNext;
        end
      end
      if (ctl.outStrobe) outReg <= stageOut;
    end
  end

  assign dataOut = outReg;

  // R5
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stageEn && !ctl.initIter) |-> (lfsr != '0));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.outStrobe |=> $stable(outReg));

  // R2
  load_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadNonce |-> !(ctl.stageEn || ctl.rotorStep));
endmodule

// File: rtl/rotor_cipher_core.sv
module rotor_cipher_core
  import rotor_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [1:0]               mode,
  input  logic [STAGES*WORD-1:0]   nonces,
  input  logic [STAGES*KEYW-1:0]   subkeys,
  input  logic [WORD-1:0]          dataIn,
  output logic [WORD-1:0]          dataOut,
  output logic                     busy,
  output logic                     ready,
  output logic                     outValid
);
  ctl_t ctl;

  rotor_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .ctl(ctl), .busy(busy), .ready(ready), .outValid(outValid)
  );

  rotor_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .nonces(nonces),
    .subkeys(subkeys), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/rotor_cipher_core_test.sv
module rotor_cipher_core_test;
  logic clk = 1'b0;
  logic rstN;
  logic startU, startP;
  logic [1:0] modeU, modeP;
  logic [15:0] dinU, dinP, doutU, doutP;
  logic busyU, busyP, readyU, readyP, validU, validP;
  logic [63:0]  seeds = 64'h3A7C_91E4_0D56_B2F8;
  logic [255:0] keys  = 256'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0_1357_9BDF_2468_ACE0_FDB9_7531_ECA8_6420;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  rotor_cipher_core uut (
    .clk(clk), .rstN(rstN), .start(startU), .mode(modeU), .nonces(seeds),
    .subkeys(keys), .dataIn(dinU), .dataOut(doutU), .busy(busyU),
    .ready(readyU), .outValid(validU)
  );

  rotor_cipher_core peer (
    .clk(clk), .rstN(rstN), .start(startP), .mode(modeP), .nonces(seeds),
    .subkeys(keys), .dataIn(dinP), .dataOut(doutP), .busy(busyP),
    .ready(readyP), .outValid(validP)
  );

  // {uutMode, peerMode, uutEnciphers, repeatOfPrevious, tag 0:R5 1:R6 2:R8, word}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 16'h0000},
    {2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 16'hFFFF},
    {2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 16'h1234},
    {2'd0, 2'd1, 1'b1, 1'b1, 2'd0, 16'h1234},
    {2'd1, 2'd0, 1'b0, 1'b0, 2'd0, 16'hA5A5},
    {2'd2, 2'd3, 1'b1, 1'b0, 2'd1, 16'h0F0F},
    {2'd2, 2'd3, 1'b0, 1'b0, 2'd1, 16'h7E81},
    {2'd2, 2'd3, 1'b1, 1'b0, 2'd1, 16'h5555},
    {2'd3, 2'd2, 1'b0, 1'b0, 2'd2, 16'h3C3C},
    {2'd3, 2'd2, 1'b1, 1'b0, 2'd1, 16'h8001},
    {2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 16'h0001},
    {2'd2, 2'd3, 1'b1, 1'b0, 2'd2, 16'h4242}
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp_);
    checks++;
    if (act !== exp_) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp_);
    end
  endtask

  task automatic doBlock(input bit onUut, input logic [1:0] m, input logic [15:0] d,
                         output logic [15:0] res, output int lat);
    @(negedge clk);
    if (onUut) begin modeU = m; dinU = d; startU = 1'b1; end
    else       begin modeP = m; dinP = d; startP = 1'b1; end
    @(negedge clk);
    startU = 1'b0;
    startP = 1'b0;
    lat = 0;
    while (!(onUut ? validU : validP) && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    res = onUut ? doutU : doutP;
  endtask

  function automatic string tagName(input logic [1:0] t);
    return (t == 2'd0) ? "R5" : ((t == 2'd1) ? "R6" : "R8");
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] ct, back, prevCt;
    int latA, latB;
    rstN = 1'b0; startU = 1'b0; startP = 1'b0;
    modeU = 2'd0; modeP = 2'd0; dinU = '0; dinP = '0;
    prevCt = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "busy in reset", {31'd0, busyU}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "busy", {31'd0, busyU}, 32'd0);
    check("R1", "ready", {31'd0, readyU}, 32'd0);
    check("R1", "outValid", {31'd0, validU}, 32'd0);
    check("R1", "dataOut", {16'd0, doutU}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] mU, mP, tg;
      logic uEnc, rep;
      logic [15:0] pt;
      {mU, mP, uEnc, rep, tg, pt} = VEC[i];
      if (uEnc) begin
        doBlock(1'b1, mU, pt, ct, latA);
        doBlock(1'b0, mP, ct, back, latB);
      end else begin
        doBlock(1'b0, mP, pt, ct, latA);
        doBlock(1'b1, mU, ct, back, latB);
      end
      check(tagName(tg), $sformatf("recovered word vec %0d", i), {16'd0, back}, {16'd0, pt});
      if (i == 0) begin
        // R2 seeding latency on both cores
        check("R2", "first block latency sender", latA, 24);
        check("R2", "first block latency receiver", latB, 24);
        check("R2", "ready after seeding", {31'd0, readyU & readyP}, 32'd1);
      end else begin
        check("R3", $sformatf("block latency vec %0d", i), latA, 4);
      end
      if (rep) check("R7", "repeated word gives new ciphertext", {31'd0, ct != prevCt}, 32'd1);
      prevCt = ct;
    end

    // R3 and R4: second start mid-block is ignored
    @(negedge clk);
    modeU = 2'd0; dinU = 16'h6B6B; startU = 1'b1;
    @(negedge clk);
    startU = 1'b0;
    @(negedge clk);
    check("R3", "busy during block", {31'd0, busyU}, 32'd1);
    modeU = 2'd1; dinU = 16'hDEAD; startU = 1'b1;
    @(negedge clk);
    startU = 1'b0;
    @(negedge clk);
    check("R4", "no early valid", {31'd0, validU}, 32'd0);
    @(negedge clk);
    check("R4", "valid on fourth edge", {31'd0, validU}, 32'd1);
    ct = doutU;
    @(negedge clk);
    check("R3", "valid is one cycle", {31'd0, validU}, 32'd0);
    check("R4", "no extra block", {31'd0, busyU}, 32'd0);
    repeat (5) @(negedge clk);
    check("R4", "still idle", {31'd0, busyU | validU}, 32'd0);
    check("R3", "dataOut holds", {16'd0, doutU}, {16'd0, ct});
    doBlock(1'b0, 2'd1, ct, back, latB);
    check("R4", "ignored start kept data and direction", {16'd0, back}, 32'h6B6B);

    // R5 roles swapped once more after the directed case
    doBlock(1'b0, 2'd0, 16'hC0DE, ct, latA);
    doBlock(1'b1, 2'd1, ct, back, latB);
    check("R5", "swapped roles", {16'd0, back}, 32'hC0DE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule